// File: doc/BRIEF.md
# Configurable memory address decoder

This block turns a 16-bit processor address and its memory-request strobe into active-low chip selects for two program EPROM sockets, a two-input battery-backed data RAM and four memory-mapped peripheral blocks. It is purely combinational, so every select follows its inputs within the same cycle.

The EPROM window size is chosen by two strap inputs fitted at board build. The first socket starts at address zero and the second socket takes the next window of the same size. An expansion-bus input can release the whole ROM and RAM space to an external card, and a separate input can release the peripheral space. A power-good input keeps the RAM deselected whenever the supply is not trustworthy, so that a falling supply cannot corrupt the stored data.

Top module: `mem_addr_decoder`

## Requirements
- R1: While `mreq_n` is high, every select output is high (inactive), whatever the other inputs are.
- R2: Strap value `strap` = {S1,S0} sets the EPROM window size: 2'b00 gives 8 KB, 2'b01 gives 16 KB and 2'b10 gives 32 KB. `rom_sel_n[0]` is low for addresses from 0x0000 up to one window, and `rom_sel_n[1]` is low for the next window. With the 8 KB size those windows are 0x0000-0x1FFF and 0x2000-0x3FFF, and with the 16 KB size they are 0x0000-0x3FFF and 0x4000-0x7FFF.
- R3: ROM decoding stops below 0xE000. With the 32 KB size, `rom_sel_n[1]` therefore covers only 0x8000-0xDFFF, and the RAM and peripheral space keeps its own selects.
- R4: Strap value 2'b11 keeps `rom_sel_n` and `ram_sel_n` high at every address. The peripheral selects still work.
- R5: When `map_en` is low, the block acts as if the strap were 2'b11, whatever value the strap pins carry.
- R6: For addresses 0xE000-0xE7FF, both bits of `ram_sel_n` go low together, and they always have the same value.
- R7: When `pwr_good` is low, both RAM selects stay high. The ROM and peripheral selects are not affected by `pwr_good`.
- R8: `per_sel_n[k]` is low for the 256-byte block that starts at 0xF000 + k*0x100, for k = 0 to 3.
- R9: When `io_sel_en` is low, all of `per_sel_n` stays high.
- R10: The following addresses select nothing: 0xE800-0xEFFF, 0xF400-0xFFFF, and the addresses above the second ROM window and below 0xE000.
- R11: At most one device is selected at any time. The RAM pair counts as one device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory-request strobe, active low |
| strap | input | 2 | EPROM size straps {S1,S0} |
| pwr_good | input | 1 | Supply good; low blocks the RAM selects |
| io_sel_en | input | 1 | Low releases the peripheral space |
| map_en | input | 1 | Low releases the ROM and RAM space |
| rom_sel_n | output | 2 | EPROM socket selects, active low |
| ram_sel_n | output | 2 | RAM chip-select pair, active low |
| per_sel_n | output | 4 | Peripheral block selects, active low |

## Verification
The cases hardest to reach are the ones that lie where two controls meet. One is the 32 KB strap setting: there the second ROM window would run into the RAM and peripheral space, and the block must cut it off exactly at 0xE000. Another is a strap setting that enables the ROM and RAM while `map_en` is low and must still suppress them. The stimulus goes to these states directly. Each strap value is driven together with addresses on both sides of every window edge, including 0xDFFF and 0xE000. Each override input is then lowered on its own while all other inputs stay at values that would otherwise select a device. A reference model written from the requirements checks every combination, and the same sweep checks that the selects never overlap.

// File: rtl/mad_pkg.sv
package mad_pkg;

   typedef enum logic [1:0] {
      ROM_8K  = 2'b00,
      ROM_16K = 2'b01,
      ROM_32K = 2'b10,
      ROM_OFF = 2'b11
   } rom_cfg_e;

   // Window size in bytes for a configuration, given the smallest window.
   function automatic int rom_window(input rom_cfg_e cfg, input int unit_bytes);
      int sz;
      case (cfg)
         ROM_8K:  sz = unit_bytes;
         ROM_16K: sz = unit_bytes * 2;
         ROM_32K: sz = unit_bytes * 4;
         default: sz = 0;
      endcase
      return sz;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mad_rom_dec.sv
module mad_rom_dec
   import mad_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int N_ROM     = 2,
   parameter int ROM_UNIT  = 8192,
   parameter int ROM_LIMIT = 16'hE000
) (
   input  logic [ADDR_W-1:0] addr,
   input  rom_cfg_e          cfg,
   output logic [N_ROM-1:0]  hit
);

   logic [31:0] a_int;
   int          win;

   always_comb begin
      a_int = 32'(addr);
      win   = rom_window(cfg, ROM_UNIT);
   end

   for (genvar k = 0; k < N_ROM; k++) begin : g_sock
      always_comb begin
         int lo;
         lo     = win * k;
         hit[k] = (cfg != ROM_OFF)
                  && (int'(a_int) >= lo)
                  && (int'(a_int) < lo + win)
                  && (int'(a_int) < ROM_LIMIT);
      end
   end

endmodule

// File: rtl/mad_ram_dec.sv
module mad_ram_dec
   import mad_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int RAM_BASE  = 16'hE000,
   parameter int RAM_BYTES = 2048
) (
   input  logic [ADDR_W-1:0] addr,
   input  rom_cfg_e          cfg,
   input  logic              pwr_good,
   output logic              hit
);

   localparam int RAM_END = RAM_BASE + RAM_BYTES;

   logic in_win;

   always_comb begin
      in_win = (int'(32'(addr)) >= RAM_BASE) && (int'(32'(addr)) < RAM_END);
      hit    = in_win && (cfg != ROM_OFF) && pwr_good;
   end

endmodule

// File: rtl/mad_per_dec.sv
module mad_per_dec #(
   parameter int ADDR_W    = 16,
   parameter int N_PER     = 4,
   parameter int PER_BASE  = 16'hF000,
   parameter int PER_BLOCK = 256
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              io_sel_en,
   output logic [N_PER-1:0]  hit
);

   logic [31:0] a_int;
   always_comb a_int = 32'(addr);

   for (genvar k = 0; k < N_PER; k++) begin : g_blk
      localparam int LO = PER_BASE + k * PER_BLOCK;
      localparam int HI = LO + PER_BLOCK;
      always_comb
         hit[k] = io_sel_en && (int'(a_int) >= LO) && (int'(a_int) < HI);
   end

endmodule

// File: rtl/mem_addr_decoder.sv
module mem_addr_decoder
   import mad_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int N_ROM     = 2,
   parameter int ROM_UNIT  = 8192,
   parameter int RAM_BASE  = 16'hE000,
   parameter int RAM_BYTES = 2048,
   parameter int N_RAM_CS  = 2,
   parameter int N_PER     = 4,
   parameter int PER_BASE  = 16'hF000,
   parameter int PER_BLOCK = 256
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                mreq_n,
   input  logic [1:0]          strap,
   input  logic                pwr_good,
   input  logic                io_sel_en,
   input  logic                map_en,
   output logic [N_ROM-1:0]    rom_sel_n,
   output logic [N_RAM_CS-1:0] ram_sel_n,
   output logic [N_PER-1:0]    per_sel_n
);

   localparam int SPACE     = 1 << ADDR_W;
   localparam int ROM_LIMIT = RAM_BASE;
   localparam int PER_END   = PER_BASE + N_PER * PER_BLOCK;

   // Elaboration-time parameter checks
   if (ADDR_W < 8 || ADDR_W > 24) begin : g_bad_aw
      $error("ADDR_W out of supported range");
   end
   if (!is_pow2(ROM_UNIT) || !is_pow2(RAM_BYTES) || !is_pow2(PER_BLOCK)) begin : g_bad_pow2
      $error("window sizes must be powers of two");
   end
   if ((RAM_BASE % RAM_BYTES) != 0 || (PER_BASE % PER_BLOCK) != 0) begin : g_bad_align
      $error("RAM or peripheral base not aligned to its size");
   end
   if (RAM_BASE + RAM_BYTES > PER_BASE || PER_END > SPACE) begin : g_bad_map
      $error("RAM and peripheral regions overlap or exceed the address space");
   end
   if (N_ROM < 1 || N_PER < 1 || N_RAM_CS < 1) begin : g_bad_cnt
      $error("select counts must be at least one");
   end

   rom_cfg_e         cfg_eff;
   logic [N_ROM-1:0] rom_hit;
   logic             ram_hit;
   logic [N_PER-1:0] per_hit;
   logic             strobe;

   always_comb begin
      cfg_eff = map_en ? rom_cfg_e'(strap) : ROM_OFF;
      strobe  = !mreq_n;
   end

   mad_rom_dec #(
      .ADDR_W   (ADDR_W),
      .N_ROM    (N_ROM),
      .ROM_UNIT (ROM_UNIT),
      .ROM_LIMIT(ROM_LIMIT)
   ) u_rom (
      .addr(addr),
      .cfg (cfg_eff),
      .hit (rom_hit)
   );

   mad_ram_dec #(
      .ADDR_W   (ADDR_W),
      .RAM_BASE (RAM_BASE),
      .RAM_BYTES(RAM_BYTES)
   ) u_ram (
      .addr    (addr),
      .cfg     (cfg_eff),
      .pwr_good(pwr_good),
      .hit     (ram_hit)
   );

   mad_per_dec #(
      .ADDR_W   (ADDR_W),
      .N_PER    (N_PER),
      .PER_BASE (PER_BASE),
      .PER_BLOCK(PER_BLOCK)
   ) u_per (
      .addr     (addr),
      .io_sel_en(io_sel_en),
      .hit      (per_hit)
   );

   always_comb begin
      rom_sel_n = ~(rom_hit & {N_ROM{strobe}});
      ram_sel_n = ~({N_RAM_CS{ram_hit & strobe}});
      per_sel_n = ~(per_hit & {N_PER{strobe}});
   end

endmodule

// File: rtl/mad_chk.sv
module mad_chk #(
   parameter int ADDR_W    = 16,
   parameter int N_ROM     = 2,
   parameter int N_RAM_CS  = 2,
   parameter int N_PER     = 4,
   parameter int RAM_BASE  = 16'hE000,
   parameter int RAM_BYTES = 2048
) (
   input logic [ADDR_W-1:0]   addr,
   input logic                mreq_n,
   input logic [1:0]          strap,
   input logic                pwr_good,
   input logic                io_sel_en,
   input logic                map_en,
   input logic [N_ROM-1:0]    rom_sel_n,
   input logic [N_RAM_CS-1:0] ram_sel_n,
   input logic [N_PER-1:0]    per_sel_n
);

   logic ram_any;
   logic mem_off;

   always_comb begin
      ram_any = !(&ram_sel_n);
      mem_off = !map_en || (strap == 2'b11);

      if (mreq_n) begin
         AST_IDLE_QUIET: assert (&{rom_sel_n, ram_sel_n, per_sel_n}); // R1
      end
      if (mem_off) begin
         AST_MEM_RELEASED: assert (&{rom_sel_n, ram_sel_n}); // R4
      end
      if (!map_en) begin
         AST_MAP_OVERRIDE: assert (&{rom_sel_n, ram_sel_n}); // R5
      end
      AST_RAM_PAIR: assert ((&ram_sel_n) || !(|ram_sel_n)); // R6
      if (!pwr_good) begin
         AST_RAM_POWER: assert (&ram_sel_n); // R7
      end
      if (!io_sel_en) begin
         AST_IO_RELEASED: assert (&per_sel_n); // R9
      end
      if (ram_any) begin
         AST_RAM_WINDOW: assert ((int'(32'(addr)) >= RAM_BASE)
                                 && (int'(32'(addr)) < RAM_BASE + RAM_BYTES)); // R6
      end
      if (!(&rom_sel_n)) begin
         AST_ROM_BELOW_RAM: assert (int'(32'(addr)) < RAM_BASE); // R3
      end
      AST_ONE_DEVICE: assert ($onehot0({~rom_sel_n, ram_any, ~per_sel_n})); // R11
   end

endmodule

bind mem_addr_decoder mad_chk #(
   .ADDR_W   (ADDR_W),
   .N_ROM    (N_ROM),
   .N_RAM_CS (N_RAM_CS),
   .N_PER    (N_PER),
   .RAM_BASE (RAM_BASE),
   .RAM_BYTES(RAM_BYTES)
) u_chk (
   .addr     (addr),
   .mreq_n   (mreq_n),
   .strap    (strap),
   .pwr_good (pwr_good),
   .io_sel_en(io_sel_en),
   .map_en   (map_en),
   .rom_sel_n(rom_sel_n),
   .ram_sel_n(ram_sel_n),
   .per_sel_n(per_sel_n)
);

// File: tb/mem_addr_decoder_tb.sv
`timescale 1ns/1ps
module mem_addr_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] addr;
   logic        mreq_n;
   logic [1:0]  strap;
   logic        pwr_good;
   logic        io_sel_en;
   logic        map_en;
   logic [1:0]  rom_sel_n;
   logic [1:0]  ram_sel_n;
   logic [3:0]  per_sel_n;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;  // 250 MHz

   mem_addr_decoder u_dut (
      .addr     (addr),
      .mreq_n   (mreq_n),
      .strap    (strap),
      .pwr_good (pwr_good),
      .io_sel_en(io_sel_en),
      .map_en   (map_en),
      .rom_sel_n(rom_sel_n),
      .ram_sel_n(ram_sel_n),
      .per_sel_n(per_sel_n)
   );

   // Reference model from the requirements: {per[3:0], ram[1:0], rom[1:0]}, active low.
   function automatic logic [7:0] mdl(input logic [15:0] a, input logic mq_n,
                                      input logic [1:0] s, input logic me,
                                      input logic pg, input logic io);
      logic [7:0] r;
      int cfg, win, ai;
      r  = 8'hFF;
      ai = int'(a);
      if (mq_n) return r;
      cfg = me ? int'(s) : 3;
      if (cfg != 3) begin
         win = 8192 << cfg;
         if (ai < 'hE000) begin
            if (ai < win)          r[0] = 1'b0;
            else if (ai < 2 * win) r[1] = 1'b0;
         end
         if (ai >= 'hE000 && ai < 'hE800 && pg) r[3:2] = 2'b00;
      end
      if (io && ai >= 'hF000 && ai < 'hF400) r[4 + ((ai - 'hF000) >> 8)] = 1'b0;
      return r;
   endfunction

   task automatic drive(input logic [15:0] a, input logic mq_n, input logic [1:0] s,
                        input logic me, input logic pg, input logic io);
      @(posedge clk);
      addr = a; mreq_n = mq_n; strap = s; map_en = me; pwr_good = pg; io_sel_en = io;
      #1;
   endtask

   task automatic check(input string req, input logic [7:0] exp);
      logic [7:0] got;
      got = {per_sel_n, ram_sel_n, rom_sel_n};
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h strap=%b me=%b pg=%b io=%b got=%b exp=%b",
                  req, addr, strap, map_en, pwr_good, io_sel_en, got, exp);
      end
   endtask

   task automatic probe(input string req, input logic [15:0] a, input logic mq_n,
                        input logic [1:0] s, input logic me, input logic pg,
                        input logic io, input logic [7:0] exp);
      drive(a, mq_n, s, me, pg, io);
      check(req, exp);
      check({req, "/model"}, mdl(a, mq_n, s, me, pg, io));
   endtask

   task automatic t_reset;
      check("R1 reset idle", 8'hFF);
   endtask

   task automatic t_strobe;
      probe("R1", 16'h0000, 1'b1, 2'b00, 1, 1, 1, 8'hFF);
      probe("R1", 16'hE000, 1'b1, 2'b00, 1, 1, 1, 8'hFF);
      probe("R1", 16'hF100, 1'b1, 2'b01, 1, 1, 1, 8'hFF);
   endtask

   task automatic t_rom_modes;
      probe("R2", 16'h1FFF, 0, 2'b00, 1, 1, 1, 8'b1111_1110);
      probe("R2", 16'h2000, 0, 2'b00, 1, 1, 1, 8'b1111_1101);
      probe("R2", 16'h3FFF, 0, 2'b00, 1, 1, 1, 8'b1111_1101);
      probe("R2", 16'h3FFF, 0, 2'b01, 1, 1, 1, 8'b1111_1110);
      probe("R2", 16'h4000, 0, 2'b01, 1, 1, 1, 8'b1111_1101);
      probe("R2", 16'h7FFF, 0, 2'b01, 1, 1, 1, 8'b1111_1101);
      probe("R3", 16'h7FFF, 0, 2'b10, 1, 1, 1, 8'b1111_1110);
      probe("R3", 16'h8000, 0, 2'b10, 1, 1, 1, 8'b1111_1101);
      probe("R3", 16'hDFFF, 0, 2'b10, 1, 1, 1, 8'b1111_1101);
      probe("R3", 16'hE000, 0, 2'b10, 1, 1, 1, 8'b1111_0011);
      probe("R3", 16'hF000, 0, 2'b10, 1, 1, 1, 8'b1110_1111);
   endtask

   task automatic t_strap_off;
      probe("R4", 16'h0000, 0, 2'b11, 1, 1, 1, 8'hFF);
      probe("R4", 16'h2000, 0, 2'b11, 1, 1, 1, 8'hFF);
      probe("R4", 16'hE400, 0, 2'b11, 1, 1, 1, 8'hFF);
      probe("R4", 16'hF200, 0, 2'b11, 1, 1, 1, 8'b1011_1111);
   endtask

   task automatic t_map;
      for (int s = 0; s < 3; s++) begin
         probe("R5", 16'h0000, 0, 2'(s), 0, 1, 1, 8'hFF);
         probe("R5", 16'hE000, 0, 2'(s), 0, 1, 1, 8'hFF);
      end
      probe("R5", 16'hF300, 0, 2'b00, 0, 1, 1, 8'b0111_1111);
   endtask

   task automatic t_ram;
      probe("R6", 16'hE000, 0, 2'b00, 1, 1, 1, 8'b1111_0011);
      probe("R6", 16'hE7FF, 0, 2'b01, 1, 1, 1, 8'b1111_0011);
   endtask

   task automatic t_power;
      probe("R7", 16'hE000, 0, 2'b00, 1, 0, 1, 8'hFF);
      probe("R7", 16'hE3A5, 0, 2'b10, 1, 0, 1, 8'hFF);
      probe("R7", 16'h0100, 0, 2'b00, 1, 0, 1, 8'b1111_1110);
      probe("R7", 16'hF0FF, 0, 2'b00, 1, 0, 1, 8'b1110_1111);
   endtask

   task automatic t_periph;
      for (int k = 0; k < 4; k++) begin
         logic [7:0] e;
         e = 8'hFF;
         e[4 + k] = 1'b0;
         probe("R8", 16'(16'hF000 + k * 256), 0, 2'b00, 1, 1, 1, e);
         probe("R8", 16'(16'hF0FF + k * 256), 0, 2'b00, 1, 1, 1, e);
      end
   endtask

   task automatic t_iodis;
      for (int k = 0; k < 4; k++)
         probe("R9", 16'(16'hF080 + k * 256), 0, 2'b00, 1, 1, 0, 8'hFF);
      probe("R9", 16'h0000, 0, 2'b00, 1, 1, 0, 8'b1111_1110);
   endtask

   task automatic t_holes;
      probe("R10", 16'hE800, 0, 2'b00, 1, 1, 1, 8'hFF);
      probe("R10", 16'hEFFF, 0, 2'b00, 1, 1, 1, 8'hFF);
      probe("R10", 16'hF400, 0, 2'b00, 1, 1, 1, 8'hFF);
      probe("R10", 16'hFFFF, 0, 2'b10, 1, 1, 1, 8'hFF);
      probe("R10", 16'h4000, 0, 2'b00, 1, 1, 1, 8'hFF);
      probe("R10", 16'h8000, 0, 2'b01, 1, 1, 1, 8'hFF);
   endtask

   // Sweep all control combinations over edge addresses against the model.
   task automatic t_sweep;
      logic [15:0] pts [0:13];
      pts = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000,
              16'hDFFF, 16'hE000, 16'hE7FF, 16'hE800, 16'hF000, 16'hF3FF, 16'hF400};
      for (int c = 0; c < 32; c++) begin
         for (int p = 0; p < 14; p++) begin
            logic [7:0] g;
            logic [6:0] dev;
            drive(pts[p], 1'b0, 2'(c), c[2], c[3], c[4]);
            check("R11/model", mdl(pts[p], 1'b0, 2'(c), c[2], c[3], c[4]));
            g   = {per_sel_n, ram_sel_n, rom_sel_n};
            dev = {~g[7:4], ~(g[3] & g[2]), ~g[1:0]};
            n_checks++;
            if ($countones(dev) > 1) begin
               n_fail++;
               $display("FAIL R11 addr=%h got=%b exp=at most one device", pts[p], g);
            end
         end
      end
   endtask

   initial begin : watchdog
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      addr = 16'h0000; mreq_n = 1'b1; strap = 2'b00;
      pwr_good = 1'b1; io_sel_en = 1'b1; map_en = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      t_reset;
      rst_n = 1'b1;
      t_strobe;
      t_rom_modes;
      t_strap_off;
      t_map;
      t_ram;
      t_power;
      t_periph;
      t_iodis;
      t_holes;
      t_sweep;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule